// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is a bus master for a two-wire serial bus with open-drain signalling. A host hands it one command at a time: start, write a byte, read a byte, or stop. The controller turns each command into clock and data activity on the two lines. It never drives a line high. Each pin has only a pull-low enable, and a released line reads high through an external pull-up. Both lines are released while the bus is idle.

Every byte takes nine clocks. The first eight carry data, most significant bit first. The ninth is the acknowledge slot. When the ninth clock ends, and also when a start condition completes, the controller raises `pending` and holds SCL low. The bus stays parked until the host issues the next command. Issuing that command clears the flag and lets clocking resume.

When the controller releases SCL, it waits until the line actually reads high before it times the high phase. This lets a slave stretch the clock. Both line inputs pass through a two-flop synchronizer before any logic uses them. Parameters set the half-bit period for standard and fast rates, and a parameter selects between the two.

Top module: `i2cByteMaster`

## Requirements
- R1: After reset, `sclOe` and `sdaOe` are 0 (both lines released), and `busy` and `pending` are 0. Whenever `busy` is 0, both enables are 0.
- R2: A start command (`cmdOp`=0) releases SDA while SCL is low, then releases SCL. Once SCL reads high, the block pulls SDA low, so SDA falls while SCL is high. It then pulls SCL low and raises `pending`. This works from idle and also as a repeated start from `pending`.
- R3: Outside the start and stop conditions, SDA changes only while SCL is held low.
- R4: A write command (`cmdOp`=1) sends `cmdData` as 8 bits, MSB first. In the 9th clock it releases SDA and samples the line: `ackRcvd` is 1 if SDA read low (ACK) and 0 if it read high (NACK).
- R5: A read command (`cmdOp`=2) releases SDA for 8 clocks and shifts the sampled bits into `rxData`, MSB first. In the 9th clock it pulls SDA low when `cmdAck`=1 and releases SDA when `cmdAck`=0.
- R6: `pending` rises after the 9th clock of every byte and after every start condition. While `pending` is 1, SCL is held low and the flag stays set until a command is accepted.
- R7: After releasing SCL, the block does not start the high phase until the synchronized SCL input reads high. While a slave holds SCL low, `sclOe` stays 0, and each SCL high period lasts at least one half-bit period.
- R8: Between bits of a byte, the SCL low phase lasts exactly HALF clock cycles. HALF is `FAST_HALF` when `FAST`=1 and `STD_HALF` otherwise.
- R9: A stop command (`cmdOp`=3) pulls SDA low while SCL is low, then releases SCL. After SCL reads high, it releases SDA, so SDA rises while SCL is high. `busy` falls after a further half-bit period.
- R10: A command issued while `busy`=1 and `pending`=0 is ignored. While the block is idle, only a start command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, sampled each cycle |
| cmdOp | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmdData | input | 8 | Byte to send for a write |
| cmdAck | input | 1 | For a read: 1 sends ACK, 0 sends NACK |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Bus owned, from start until stop completes |
| pending | output | 1 | Byte or start done; SCL parked low |
| rxData | output | 8 | Last byte read |
| ackRcvd | output | 1 | 1 if the last 9th-clock sample was low |

## Verification
The bench runs a behavioural slave and a line monitor. The monitor decodes start, stop and byte events from the wired-AND levels and compares each byte against a queue of expected values. It sends both ACK and NACK and returns read data with both acknowledge choices, so a controller that swapped the sense of the acknowledge bit, or shifted LSB first, would put wrong bytes on the bus. The slave holds SCL low for longer than a half-bit period. A controller that timed the high phase from its own release would pull SCL low again during the stretch, or lose a clock. The bench also issues a stop in the middle of a byte and a write while idle. A controller that accepted either would produce an extra stop event or start clocking from idle. While `pending` is set, SCL is checked on every cycle to confirm it stays parked.

// File: rtl/i2cmPkg.sv
package i2cmPkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } cmdOp_t;

  typedef enum logic [3:0] {
    S_IDLE, S_SLOW, S_SWAIT, S_SHIGH, S_SHOLD, S_PEND,
    S_BLOW, S_BWAIT, S_BHIGH, S_PLOW, S_PWAIT, S_PHIGH, S_PFREE
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic loadTx;
    logic loadRead;
    logic sendBit;
    logic shiftIn;
    logic sampleAck;
    logic sclPull;
    logic sclRel;
    logic sdaPull;
    logic sdaRel;
  } dpCtl_t;

endpackage

// File: rtl/i2cmData.sv
module i2cmData
  import i2cmPkg::*;
#(
  parameter int HALF = 6,
  parameter int QTR  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [7:0] txIn,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclS,
  output logic       qtrHit,
  output logic       halfHit,
  output logic       sclOe,
  output logic       sdaOe,
  output logic [7:0] rxData,
  output logic       ackRcvd
);

  localparam int CW = $clog2(HALF + 1);

  logic [1:0]    sclSync, sdaSync;
  logic          sdaS;
  logic [CW-1:0] cnt;
  logic [7:0]    txSh;

  // two-flop synchronizers, reset to the idle (high) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];

  // phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign qtrHit  = (cnt == CW'(QTR - 1));
  assign halfHit = (cnt == CW'(HALF - 1));

  // shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= 8'hFF;
      rxData  <= 8'h00;
      ackRcvd <= 1'b0;
    end else begin
      if (ctl.loadTx)        txSh <= txIn;
      else if (ctl.loadRead) txSh <= 8'hFF;
      else if (ctl.shiftIn)  txSh <= {txSh[6:0], 1'b1};
      if (ctl.shiftIn)   rxData  <= {rxData[6:0], sdaS};
      if (ctl.sampleAck) ackRcvd <= ~sdaS;
    end
  end

  // open-drain pin enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      if (ctl.sclPull)     sclOe <= 1'b1;
      else if (ctl.sclRel) sclOe <= 1'b0;
      if (ctl.sdaPull)      sdaOe <= 1'b1;
      else if (ctl.sdaRel)  sdaOe <= 1'b0;
      else if (ctl.sendBit) sdaOe <= ~txSh[7];
    end
  end

endmodule

// File: rtl/i2cmCtrl.sv
module i2cmCtrl
  import i2cmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdAck,
  input  logic       sclS,
  input  logic       qtrHit,
  input  logic       halfHit,
  output dpCtl_t     ctl,
  output ctlState_t  st,
  output logic       busy,
  output logic       pending
);

  ctlState_t nxt;
  logic [3:0] bitIdx;
  logic       ackSendR;
  cmdOp_t     op;
  logic       lastBit;

  assign op      = cmdOp_t'(cmdOp);
  assign lastBit = (bitIdx == 4'd8);
  assign busy    = (st != S_IDLE);
  assign pending = (st == S_PEND);

  always_comb begin
    ctl = '0;
    nxt = st;
    unique case (st)
      S_IDLE: begin
        ctl.cntClr = 1'b1;
        if (cmdValid && op == OP_START) nxt = S_SLOW;
      end
      S_PEND: begin
        ctl.cntClr = 1'b1;
        if (cmdValid) begin
          unique case (op)
            OP_START: nxt = S_SLOW;
            OP_WRITE: begin ctl.loadTx = 1'b1;   nxt = S_BLOW; end
            OP_READ:  begin ctl.loadRead = 1'b1; nxt = S_BLOW; end
            OP_STOP:  nxt = S_PLOW;
          endcase
        end
      end
      S_SLOW: begin
        if (qtrHit) ctl.sdaRel = 1'b1;
        if (halfHit) begin ctl.sclRel = 1'b1; ctl.cntClr = 1'b1; nxt = S_SWAIT; end
      end
      S_SWAIT: begin
        ctl.cntClr = 1'b1;
        if (sclS) nxt = S_SHIGH;
      end
      S_SHIGH: begin
        if (halfHit) begin ctl.sdaPull = 1'b1; ctl.cntClr = 1'b1; nxt = S_SHOLD; end
      end
      S_SHOLD: begin
        if (halfHit) begin ctl.sclPull = 1'b1; ctl.cntClr = 1'b1; nxt = S_PEND; end
      end
      S_BLOW: begin
        if (qtrHit) begin
          if (!lastBit)      ctl.sendBit = 1'b1;
          else if (ackSendR) ctl.sdaPull = 1'b1;
          else               ctl.sdaRel  = 1'b1;
        end
        if (halfHit) begin ctl.sclRel = 1'b1; ctl.cntClr = 1'b1; nxt = S_BWAIT; end
      end
      S_BWAIT: begin
        ctl.cntClr = 1'b1;
        if (sclS) nxt = S_BHIGH;
      end
      S_BHIGH: begin
        if (halfHit) begin
          ctl.sclPull = 1'b1;
          ctl.cntClr  = 1'b1;
          if (lastBit) begin ctl.sampleAck = 1'b1; nxt = S_PEND; end
          else begin ctl.shiftIn = 1'b1; nxt = S_BLOW; end
        end
      end
      S_PLOW: begin
        if (qtrHit) ctl.sdaPull = 1'b1;
        if (halfHit) begin ctl.sclRel = 1'b1; ctl.cntClr = 1'b1; nxt = S_PWAIT; end
      end
      S_PWAIT: begin
        ctl.cntClr = 1'b1;
        if (sclS) nxt = S_PHIGH;
      end
      S_PHIGH: begin
        if (halfHit) begin ctl.sdaRel = 1'b1; ctl.cntClr = 1'b1; nxt = S_PFREE; end
      end
      S_PFREE: begin
        if (halfHit) begin ctl.cntClr = 1'b1; nxt = S_IDLE; end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= S_IDLE;
      bitIdx   <= 4'd0;
      ackSendR <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_PEND && cmdValid && (op == OP_WRITE || op == OP_READ)) begin
        bitIdx   <= 4'd0;
        ackSendR <= (op == OP_READ) && cmdAck;
      end else if (st == S_BHIGH && halfHit && !lastBit) begin
        bitIdx <= bitIdx + 4'd1;
      end
    end
  end

endmodule

// File: rtl/i2cByteMaster.sv
module i2cByteMaster
  import i2cmPkg::*;
#(
  parameter int STD_HALF  = 625,
  parameter int FAST_HALF = 156,
  parameter bit FAST      = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [7:0] cmdData,
  input  logic       cmdAck,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       busy,
  output logic       pending,
  output logic [7:0] rxData,
  output logic       ackRcvd
);

  localparam int HALF = FAST ? FAST_HALF : STD_HALF;
  localparam int QTR  = HALF / 2;

  dpCtl_t    ctl;
  ctlState_t st;
  logic      sclS, qtrHit, halfHit;

  i2cmCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAck(cmdAck), .sclS(sclS), .qtrHit(qtrHit), .halfHit(halfHit),
    .ctl(ctl), .st(st), .busy(busy), .pending(pending)
  );

  i2cmData #(.HALF(HALF), .QTR(QTR)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txIn(cmdData),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclS(sclS), .qtrHit(qtrHit),
    .halfHit(halfHit), .sclOe(sclOe), .sdaOe(sdaOe),
    .rxData(rxData), .ackRcvd(ackRcvd)
  );

endmodule

// File: rtl/i2cmChk.sv
module i2cmChk
  import i2cmPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       sclIn,
  input logic       busy,
  input logic       pending,
  input logic       cmdValid,
  input logic [1:0] cmdOp,
  input ctlState_t  st
);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));

  a_r6_pend_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> sclOe);

  a_r6_pend_waits: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !cmdValid) |=> pending);

  a_r10_idle_only_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp != 2'd0) |=> !busy);

  // R3: an SDA change with SCL released on both sides is a start or stop edge
  a_r3_sda_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && !$past(sclOe) && sclIn && $past(sclIn) && (sdaOe != $past(sdaOe)))
      |-> (st == S_SHOLD || st == S_PFREE));

  a_r7_stretch_wait: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sclOe && !sclIn) |=> !sclOe);

endmodule

bind i2cByteMaster i2cmChk u_chk (
  .clk(clk), .rstN(rstN), .sclOe(sclOe), .sdaOe(sdaOe), .sclIn(sclIn),
  .busy(busy), .pending(pending), .cmdValid(cmdValid), .cmdOp(cmdOp), .st(st)
);

// File: tb/i2cByteMaster_tb.sv
`timescale 1ns/1ps
module i2cByteMaster_tb;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] cmdData = 8'h00;
  logic       cmdAck = 1'b0;
  logic       sclIn, sdaIn, sclOe, sdaOe, busy, pending, ackRcvd;
  logic [7:0] rxData;

  logic       stretch = 1'b0;
  logic       slvSda = 1'b0;
  logic       txMode = 1'b0;
  logic       ackEn = 1'b1;
  logic [7:0] txByte = 8'h00;

  int total = 0;
  int bad = 0;
  int starts = 0;
  int stops = 0;
  int bitCnt = 0;
  int lowLen = 0;
  int highLen = 0;
  logic stretchSeen = 1'b0;
  logic prevScl = 1'b1;
  logic prevSda = 1'b1;
  logic [8:0] shiftR = '0;
  logic [8:0] expQ[$];

  always #4 clk = ~clk;

  assign sclIn = ~(sclOe | stretch);
  assign sdaIn = ~(sdaOe | slvSda);

  i2cByteMaster #(.STD_HALF(12), .FAST_HALF(HALF), .FAST(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdAck(cmdAck), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .pending(pending),
    .rxData(rxData), .ackRcvd(ackRcvd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line monitor and behavioural slave, evaluated away from the active edge
  always @(negedge clk) begin
    logic scl, sda;
    logic [8:0] e;
    if (rstN) begin
      scl = sclIn;
      sda = sdaIn;
      if (pending) chk(scl == 1'b0, "R6 scl parked low", scl, 0);
      if (scl && prevScl && sda != prevSda) begin
        if (!sda) begin starts++; bitCnt = 0; end
        else stops++;
      end else if (scl && !prevScl) begin
        if (bitCnt >= 1 && bitCnt <= 8 && !stretchSeen)
          chk(lowLen == HALF, "R8 scl low phase", lowLen, HALF);
        shiftR = {shiftR[7:0], sda};
        bitCnt++;
        if (bitCnt == 9) begin
          bitCnt = 0;
          if (expQ.size() == 0) chk(1'b0, "R4 unexpected byte", shiftR, 0);
          else begin
            e = expQ.pop_front();
            chk(shiftR == e, "R4 R5 byte and ack on bus", shiftR, e);
          end
        end
        highLen = 0;
      end else if (!scl && prevScl) begin
        chk(highLen >= HALF, "R7 scl high time", highLen, HALF);
        lowLen = 0;
        stretchSeen = 1'b0;
      end
      if (scl) highLen++; else lowLen++;
      if (stretch) stretchSeen = 1'b1;
      if (!scl) begin
        if (bitCnt < 8) slvSda = txMode & ~txByte[7 - bitCnt];
        else            slvSda = txMode ? 1'b0 : ackEn;
      end
      prevScl = scl;
      prevSda = sda;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic a);
    @(posedge clk); #1;
    cmdValid = 1'b1; cmdOp = op; cmdData = d; cmdAck = a;
    @(posedge clk); #1;
    cmdValid = 1'b0;
  endtask

  task automatic waitPend(input string tag);
    for (int i = 0; i < 4000; i++) begin
      if (pending) break;
      @(posedge clk); #1;
    end
    chk(pending == 1'b1, tag, pending, 1);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #2;
    chk({sclOe, sdaOe, busy, pending} == 4'b0, "R1 reset state", {sclOe, sdaOe, busy, pending}, 0);

    // write while idle must be ignored
    issue(2'd1, 8'hAA, 1'b0);
    repeat (20) @(posedge clk); #1;
    chk(busy == 1'b0, "R10 idle write ignored busy", busy, 0);
    chk(sclOe == 1'b0, "R10 idle write ignored scl", sclOe, 0);

    // start
    issue(2'd0, 8'h00, 1'b0);
    waitPend("R6 pending after start");
    chk(starts == 1, "R2 start seen", starts, 1);
    chk(busy == 1'b1, "R2 busy after start", busy, 1);

    // address write with ACK
    ackEn = 1'b1;
    expQ.push_back({8'hA4, 1'b0});
    issue(2'd1, 8'hA4, 1'b0);
    waitPend("R6 pending after write");
    chk(ackRcvd == 1'b1, "R4 ack received", ackRcvd, 1);

    // write with NACK
    ackEn = 1'b0;
    expQ.push_back({8'h3C, 1'b1});
    issue(2'd1, 8'h3C, 1'b0);
    waitPend("R6 pending after nack write");
    chk(ackRcvd == 1'b0, "R4 nack received", ackRcvd, 0);

    // parked bus holds
    repeat (50) @(posedge clk); #1;
    chk(pending == 1'b1, "R6 pending held", pending, 1);
    chk(sclOe == 1'b1, "R6 scl held", sclOe, 1);

    // read with ACK
    txMode = 1'b1; txByte = 8'h96;
    expQ.push_back({8'h96, 1'b0});
    issue(2'd2, 8'h00, 1'b1);
    waitPend("R6 pending after read");
    txMode = 1'b0;
    chk(rxData == 8'h96, "R5 read data", rxData, 8'h96);

    // read with NACK
    txMode = 1'b1; txByte = 8'h5B;
    expQ.push_back({8'h5B, 1'b1});
    issue(2'd2, 8'h00, 1'b0);
    waitPend("R6 pending after read nack");
    txMode = 1'b0;
    chk(rxData == 8'h5B, "R5 read data nack", rxData, 8'h5B);

    // stop issued mid-byte must be ignored
    ackEn = 1'b1;
    expQ.push_back({8'h81, 1'b0});
    issue(2'd1, 8'h81, 1'b0);
    repeat (10) @(posedge clk);
    issue(2'd3, 8'h00, 1'b0);
    waitPend("R10 byte completes despite stop");
    chk(stops == 0, "R10 mid-byte stop ignored", stops, 0);

    // clock stretching
    expQ.push_back({8'h55, 1'b0});
    issue(2'd1, 8'h55, 1'b0);
    repeat (30) @(posedge clk); #1;
    for (int i = 0; i < 200; i++) begin
      if (sclOe) break;
      @(posedge clk); #1;
    end
    stretch = 1'b1;
    repeat (25) @(posedge clk); #1;
    chk(sclOe == 1'b0, "R7 master waits while stretched", sclOe, 0);
    stretch = 1'b0;
    waitPend("R7 byte done after stretch");
    chk(ackRcvd == 1'b1, "R7 ack after stretch", ackRcvd, 1);

    // repeated start
    issue(2'd0, 8'h00, 1'b0);
    waitPend("R2 pending after repeated start");
    chk(starts == 2, "R2 repeated start seen", starts, 2);

    // stop
    issue(2'd3, 8'h00, 1'b0);
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      @(posedge clk); #1;
    end
    chk(stops == 1, "R9 stop seen", stops, 1);
    chk(busy == 1'b0, "R9 busy cleared", busy, 0);
    chk({sclIn, sdaIn} == 2'b11, "R1 lines high after stop", {sclIn, sdaIn}, 3);
    chk(expQ.size() == 0, "R4 all bytes seen", expQ.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule